// File: doc/BRIEF.md
# Sticky Error Status Register Bank

This block keeps a byte-wide bank of latched error flags behind a small register port. Each flag captures an already-decided error level and stays set after the error goes away. Software clears a flag by writing a one to its position. An optional mode input also lets a read of the status register clear it. A clear is refused while the flag's error is still active and unmasked. A summary output reports that any flag is set, and an alert output follows the summary when software enables it.

Masking depends on the sleep state, which software writes as a 2-bit code. Some error positions are always masked while asleep. Some are masked while asleep only when software sets their select bit. The rest are never masked. A masked error cannot set its flag, and a masked flag can be cleared even if its error persists. Which positions fall in each class is set by parameters.

Top module: `sticky_err_bank`

## Requirements
- R1: When error input i is high and unmasked at a rising clock edge, status bit i reads 1 afterwards and stays 1 after the input returns low, until it is cleared.
- R2: Writing the status register (address 0) with bit i set to 1 clears status bit i when error i is low or masked. Bits written as 0 are left unchanged.
- R3: A write-one clear or a read clear has no effect on a status bit whose error input is high and unmasked in that cycle.
- R4: An error that is masked in a cycle does not set its status bit in that cycle.
- R5: The sleep code is bits 1:0 at address 1: 00 means awake, 01 means S3, 10 means S4/5, and 11 is treated as awake. Error bits 4 and 5 are masked in S3 and S4/5. Bits 0 and 1 are masked in S3 and S4/5 only when their select bit (bit 0 or bit 1 at address 2) is 1. Bits 2 and 3 are never masked.
- R6: When rtc_mode_i is high, a read of address 0 returns the value before the clear and then clears every eligible bit, using the same rule as R2 and R3. When rtc_mode_i is low, reads change nothing.
- R7: summary_o is 1 exactly when some status bit is 1. alert_o equals summary_o AND the alert-enable bit (bit 0 at address 3). Bit 7 at address 3 reads back summary_o.
- R8: All registers reset to zero. Status bits 7:6 always read 0 and ignore writes. Read data appears on reg_rdata_o one clock after the cycle in which reg_rd_i is high.
- R9: When an error sets a bit in the same cycle that a write tries to clear it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | NUM_ERR | Error level inputs, one per status bit |
| rtc_mode_i | input | 1 | Enables read-to-clear of the status register |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | DATA_W | Registered read data |
| summary_o | output | 1 | Any status bit set |
| alert_o | output | 1 | Summary gated by alert enable |

## Verification
The bench uses the default configuration: an 8-bit data path, six error positions, bits 4 and 5 always masked while asleep, and bits 0 and 1 optionally masked. With only six error inputs and a 2-bit mask select, it can sweep every sleep code against every select value and every error pattern. Each of these cases is checked against a mask that the bench computes arithmetically. Directed sequences then cover blocked clears, clearing a masked bit whose error is still active, read-to-clear with the mode on and off, and a set that collides with a clear.

// File: rtl/sticky_err_pkg.sv
package sticky_err_pkg;

   typedef enum logic [1:0] {
      SLP_AWAKE = 2'b00,
      SLP_S3    = 2'b01,
      SLP_S45   = 2'b10,
      SLP_RSVD  = 2'b11
   } sleep_e;

   localparam int unsigned REG_ADDR_W = 2;

   localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADDR_SLEEP  = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADDR_MSEL   = 2'd2;
   localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd3;

   function automatic logic is_asleep(input sleep_e s);
      return (s == SLP_S3) || (s == SLP_S45);
   endfunction

endpackage

// File: rtl/err_mask_decode.sv
module err_mask_decode
   import sticky_err_pkg::*;
#(
   parameter int unsigned NUM_ERR = 6,
   parameter logic [NUM_ERR-1:0] ALWAYS_MASK = 6'b110000,
   parameter logic [NUM_ERR-1:0] OPT_MASK    = 6'b000011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sleep_e             sleep_i,
   input  logic [NUM_ERR-1:0] opt_sel_i,
   output logic [NUM_ERR-1:0] mask_o
);

   logic asleep;
   assign asleep = is_asleep(sleep_i);

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
      if (ALWAYS_MASK[i]) begin : g_always
         assign mask_o[i] = asleep;
      end else if (OPT_MASK[i]) begin : g_opt
         assign mask_o[i] = asleep & opt_sel_i[i];
      end else begin : g_never
         assign mask_o[i] = 1'b0;
      end
   end

   // R5
   awake_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i == SLP_AWAKE || sleep_i == SLP_RSVD) |-> (mask_o == '0));

   // R5
   never_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_o & ~(ALWAYS_MASK | OPT_MASK)) == '0));

endmodule

// File: rtl/err_status_cell.sv
module err_status_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic err_i,
   input  logic mask_i,
   input  logic w1c_i,
   input  logic rtc_i,
   output logic sts_q
);

   logic set_ev;
   logic clr_ok;
   logic clr_req;

   assign set_ev  = err_i & ~mask_i;
   assign clr_ok  = ~err_i | mask_i;
   assign clr_req = (w1c_i | rtc_i) & clr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sts_q <= 1'b0;
      else if (set_ev)
         sts_q <= 1'b1;
      else if (clr_req)
         sts_q <= 1'b0;
   end

   // R1
   set_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && !mask_i) |=> sts_q);

   // R3
   clear_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && err_i && !mask_i && (w1c_i || rtc_i)) |=> sts_q);

   // R4
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_q && (!err_i || mask_i)) |=> !sts_q);

   // R2
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && w1c_i && (!err_i || mask_i)) |=> !sts_q);

   // R1
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !w1c_i && !rtc_i) |=> sts_q);

endmodule

// File: rtl/sticky_err_cfg.sv
module sticky_err_cfg
   import sticky_err_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_ERR = 6,
   parameter logic [NUM_ERR-1:0] OPT_MASK = 6'b000011
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output sleep_e                sleep_o,
   output logic [NUM_ERR-1:0]    opt_sel_o,
   output logic                  alert_en_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sleep_o <= SLP_AWAKE;
      else if (wr_i && addr_i == ADDR_SLEEP)
         sleep_o <= sleep_e'(wdata_i[1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         alert_en_o <= 1'b0;
      else if (wr_i && addr_i == ADDR_CTRL)
         alert_en_o <= wdata_i[0];
   end

   if (OPT_MASK == '0) begin : g_no_sel
      assign opt_sel_o = '0;
   end else begin : g_sel
      logic [NUM_ERR-1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q <= '0;
         else if (wr_i && addr_i == ADDR_MSEL)
            sel_q <= wdata_i[NUM_ERR-1:0] & OPT_MASK;
      end
      assign opt_sel_o = sel_q;
   end

   // R5
   sleep_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_SLEEP) |=> (sleep_o == sleep_e'($past(wdata_i[1:0]))));

   // R7
   alert_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_CTRL) |=> (alert_en_o == $past(wdata_i[0])));

endmodule

// File: rtl/sticky_err_bank.sv
module sticky_err_bank
   import sticky_err_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_ERR = 6,
   parameter logic [NUM_ERR-1:0] ALWAYS_MASK = 6'b110000,
   parameter logic [NUM_ERR-1:0] OPT_MASK    = 6'b000011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] err_i,
   input  logic               rtc_mode_i,
   input  logic [1:0]         reg_addr_i,
   input  logic               reg_wr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   input  logic               reg_rd_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               summary_o,
   output logic               alert_o
);

   localparam int unsigned SPARE_W = DATA_W - NUM_ERR;

   if (NUM_ERR > DATA_W) begin : g_bad_width
      $error("NUM_ERR must not exceed DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold the sleep code");
   end
   if ((ALWAYS_MASK & OPT_MASK) != '0) begin : g_bad_class
      $error("a bit cannot be both always and optionally masked");
   end

   sleep_e             sleep_q;
   logic [NUM_ERR-1:0] opt_sel;
   logic               alert_en;
   logic [NUM_ERR-1:0] mask;
   logic [NUM_ERR-1:0] sts;
   logic [NUM_ERR-1:0] w1c_vec;
   logic               rtc_hit;
   logic               sel_status;
   logic [DATA_W-1:0]  rd_mux;

   sticky_err_cfg #(
      .DATA_W   (DATA_W),
      .NUM_ERR  (NUM_ERR),
      .OPT_MASK (OPT_MASK)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (reg_wr_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .sleep_o    (sleep_q),
      .opt_sel_o  (opt_sel),
      .alert_en_o (alert_en)
   );

   err_mask_decode #(
      .NUM_ERR     (NUM_ERR),
      .ALWAYS_MASK (ALWAYS_MASK),
      .OPT_MASK    (OPT_MASK)
   ) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_i   (sleep_q),
      .opt_sel_i (opt_sel),
      .mask_o    (mask)
   );

   assign sel_status = (reg_addr_i == ADDR_STATUS);
   assign w1c_vec    = (reg_wr_i && sel_status) ? reg_wdata_i[NUM_ERR-1:0] : '0;
   assign rtc_hit    = reg_rd_i && sel_status && rtc_mode_i;

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_cell
      err_status_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .err_i  (err_i[i]),
         .mask_i (mask[i]),
         .w1c_i  (w1c_vec[i]),
         .rtc_i  (rtc_hit),
         .sts_q  (sts[i])
      );
   end

   assign summary_o = |sts;
   assign alert_o   = summary_o & alert_en;

   always_comb begin
      rd_mux = '0;
      unique case (reg_addr_i)
         ADDR_STATUS: rd_mux[NUM_ERR-1:0] = sts;
         ADDR_SLEEP:  rd_mux[1:0]         = sleep_q;
         ADDR_MSEL:   rd_mux[NUM_ERR-1:0] = opt_sel;
         ADDR_CTRL: begin
            rd_mux[0]        = alert_en;
            rd_mux[DATA_W-1] = summary_o;
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata_o <= '0;
      else if (reg_rd_i)
         reg_rdata_o <= rd_mux;
   end

   // R7
   alert_needs_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert_o) |-> summary_o);

   // R6
   rtc_pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && sel_status) |=> (reg_rdata_o[NUM_ERR-1:0] == $past(sts)));

   // R6
   no_rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && sel_status && !rtc_mode_i && !reg_wr_i) |=> ((sts & $past(sts)) == $past(sts)));

   if (SPARE_W > 0) begin : g_spare_chk
      // R8
      spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd_i && sel_status) |=> (reg_rdata_o[DATA_W-1:NUM_ERR] == '0));
   end

endmodule

// File: tb/tb_sticky_err_bank.sv
module tb_sticky_err_bank;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] err = '0;
   logic       rtc_mode = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       summary;
   logic       alert;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sticky_err_bank dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .err_i       (err),
      .rtc_mode_i  (rtc_mode),
      .reg_addr_i  (addr),
      .reg_wr_i    (wr_en),
      .reg_wdata_i (wdata),
      .reg_rd_i    (rd_en),
      .reg_rdata_o (rdata),
      .summary_o   (summary),
      .alert_o     (alert)
   );

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk);
      addr = a; wdata = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [5:0] p);
      @(negedge clk);
      err = p;
      @(negedge clk);
      err = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [5:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], d);
         check8(d, 8'h00, "R8 reset register");
      end
      check8({6'b0, summary, alert}, 8'h00, "R8 reset outputs");

      wr(2'd3, 8'h01);

      // R1 R4 R5 R7 R2 sweep
      for (int ss = 0; ss < 4; ss++) begin
         for (int sel = 0; sel < 4; sel++) begin
            wr(2'd1, 8'(ss));
            wr(2'd2, 8'(sel));
            m = (ss == 1 || ss == 2) ? (6'h30 | 6'(sel)) : 6'h00;
            for (int p = 0; p < 64; p++) begin
               pulse(6'(p));
               rd(2'd0, d);
               check8(d, {2'b00, 6'(p) & ~m}, "R1/R4/R5 sweep status");
               check8({7'b0, summary}, {7'b0, ((6'(p) & ~m) != 0)}, "R7 summary");
               check8({7'b0, alert}, {7'b0, ((6'(p) & ~m) != 0)}, "R7 alert");
               wr(2'd0, 8'h3F);
               rd(2'd0, d);
               check8(d, 8'h00, "R2 clear after sweep");
            end
         end
      end
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);

      // R5 readback of sleep code and select
      wr(2'd1, 8'h02); rd(2'd1, d); check8(d, 8'h02, "R5 sleep readback");
      wr(2'd2, 8'hFF); rd(2'd2, d); check8(d, 8'h03, "R5 select readback");
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);

      // R2 partial write leaves other bits
      pulse(6'h0C);
      wr(2'd0, 8'h04);
      rd(2'd0, d); check8(d, 8'h08, "R2 zero bits untouched");
      wr(2'd0, 8'h08);

      // R3 blocked clear while unmasked error active
      @(negedge clk); err = 6'h04;
      wr(2'd0, 8'h04);
      rd(2'd0, d); check8(d, 8'h04, "R3 blocked w1c");
      @(negedge clk); err = 6'h00;
      wr(2'd0, 8'h04);
      rd(2'd0, d); check8(d, 8'h00, "R2 clear after error gone");

      // R2 masked clear with active error, R4 no re-set while masked
      @(negedge clk); err = 6'h01;
      rd(2'd0, d); check8(d, 8'h01, "R1 zone bit set awake");
      wr(2'd2, 8'h01);
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h01);
      rd(2'd0, d); check8(d, 8'h00, "R2 masked clear while active");
      rd(2'd0, d); check8(d, 8'h00, "R4 masked error does not set");
      @(negedge clk); err = 6'h00;
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);

      // R6 read-to-clear off: reads keep bits
      pulse(6'h02);
      rd(2'd0, d); check8(d, 8'h02, "R6 read mode off first");
      rd(2'd0, d); check8(d, 8'h02, "R6 read mode off second");
      wr(2'd0, 8'h02);

      // R6 read-to-clear on
      rtc_mode = 1'b1;
      pulse(6'h06);
      rd(2'd0, d); check8(d, 8'h06, "R6 pre-clear value");
      rd(2'd0, d); check8(d, 8'h00, "R6 cleared by read");
      // R3 read clear blocked while active
      @(negedge clk); err = 6'h04;
      rd(2'd0, d); check8(d, 8'h04, "R3 rtc active read");
      rd(2'd0, d); check8(d, 8'h04, "R3 rtc blocked");
      @(negedge clk); err = 6'h00;
      rd(2'd0, d); check8(d, 8'h04, "R6 rtc after release");
      rd(2'd0, d); check8(d, 8'h00, "R6 rtc cleared");
      rtc_mode = 1'b0;

      // R9 set wins over clear in same cycle
      @(negedge clk);
      err = 6'h08; addr = 2'd0; wdata = 8'h08; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; err = 6'h00;
      rd(2'd0, d); check8(d, 8'h08, "R9 set wins");

      // R7 alert disabled, summary in ctrl register
      wr(2'd3, 8'h00);
      @(negedge clk);
      check8({6'b0, summary, alert}, 8'h02, "R7 alert gated off");
      rd(2'd3, d); check8(d, 8'h80, "R7 summary readback");

      // R8 spare bits ignore writes and read zero
      wr(2'd0, 8'hC0);
      rd(2'd0, d); check8(d, 8'h08, "R8 spare write ignored");
      wr(2'd0, 8'hFF);
      rd(2'd0, d); check8(d, 8'h00, "R8 full clear");
      check8({7'b0, summary}, 8'h00, "R7 summary low");

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule